// File: doc/BRIEF.md
# Angle Output Holding Latch with Deferred Freeze

This block is the digital output stage of a tracking angle converter. A 16-bit angle count moves one step at a time, up or down, in response to step requests. The requests pass through a short queue, so that consecutive steps are spaced out. Every applied step raises a busy pulse of fixed length, and a programmable idle gap must pass before the next pulse can start. A holding register follows the settled count and never shows a count that is still changing.

An active-low inhibit freezes the holding register so that a host can read the angle in two byte transfers without tearing, while the count underneath keeps tracking. The host does not need to watch the busy line. If inhibit arrives during a pulse, the freeze waits for the edge that ends the pulse and captures the new count there. The held word is presented on a shared byte bus through two active-low enables, one for the upper byte and one for the lower. Pulling both enables low also presents the full 16-bit word on a separate wide view. Tri-state behaviour is modelled by a drive flag, and the data is forced to zero whenever the flag is low.

A resolution select picks fine stepping (one count) or coarse stepping (four counts, with the two lowest bits cleared). The select may change at any time and is sampled when each step is applied.

Top module: `angle_out_latch`

## Requirements
- R1: On `step_up` = 1 an applied step adds one count, and on `step_up` = 0 it subtracts one. The count wraps modulo 2^16, so that up from 0xFFFF gives 0x0000 and down from 0x0000 gives 0xFFFF. The count changes on the same edge at which `busy` rises, and at no other edge.
- R2: With `res_hi` = 0 sampled at the edge where a step is applied, bits 15..2 step by one in the requested direction and bits 1..0 become 0. For example, an up step from 0x0005 gives 0x0008.
- R3: Each applied step holds `busy` high for exactly BUSY_CYC consecutive cycles (4 by default).
- R4: Between two busy pulses, `busy` stays low for at least `gap_cfg`+1 cycles. `gap_cfg` is sampled at the edge that ends the earlier pulse. When steps are waiting, the low time is exactly `gap_cfg`+1 cycles.
- R5: `step_req` is sampled at each edge and enqueues one step in the direction given by `step_up`. Up to Q_DEPTH (4 by default) steps wait, in order of arrival. A request is dropped when the queue is full and no step leaves it in the same cycle. A step that arrives at an idle, empty block is applied at the following edge.
- R6: The held word never shows a count from inside a pulse. While `busy` is high it keeps the pre-step count, and at the edge ending the pulse it takes the new count.
- R7: When `inh_n` is sampled low while `busy` is low, the held word stays frozen at the count of that edge until inhibit is released. Further steps still move the count underneath.
- R8: When `inh_n` is sampled low while `busy` is high, the freeze takes effect at the edge that ends the pulse, and the held word captures the new count there.
- R9: An edge that samples `inh_n` high while `busy` is low loads the current count into the held word. Any steps taken during the freeze therefore appear one cycle after release.
- R10: With `en_msb_n` low, `bus_data` carries held bits 15..8. With only `en_lsb_n` low, it carries held bits 7..0. The upper byte wins when both enables are low. `bus_drive` is 1 in all of these cases.
- R11: With both enables high, `bus_drive` and `wide_drive` are 0, and `bus_data` and `wide_data` are 0.
- R12: With both enables low, `wide_data` equals the held word and `wide_drive` is 1. With only one enable low, `wide_data` is 0 and `wide_drive` is 0.
- R13: After reset, the count and the held word are 0x0000, `busy` is 0, the queue is empty and no freeze is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_req | input | 1 | Step strobe, one step per sampled cycle |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| res_hi | input | 1 | 1 fine stepping, 0 coarse stepping by four |
| gap_cfg | input | GAP_W (4) | Minimum idle gap between pulses, minus one |
| inh_n | input | 1 | Active-low freeze request for the held word |
| en_msb_n | input | 1 | Active-low upper byte enable |
| en_lsb_n | input | 1 | Active-low lower byte enable |
| busy | output | 1 | High while a step settles |
| bus_data | output | BYTE_W (8) | Shared byte bus data |
| bus_drive | output | 1 | Byte bus is driven |
| wide_data | output | 2*BYTE_W (16) | Full held word view |
| wide_drive | output | 1 | Wide view is driven |

## Verification
The bench applies inhibit at random offsets inside and outside busy pulses. A latch that froze immediately would hold the pre-step count or a count from inside the pulse, where the correct held word is the count at the end of the pulse. Directed cases step across both wrap points and switch to coarse stepping from a count whose low bits are not zero. A missing wrap, or a coarse step that keeps the low bits, shows up directly in the held word. A burst of six strobes into a queue of four must yield exactly five steps, and gap settings of 0 and 3 must give low times of exactly 1 and 4 cycles. Off-by-one errors in the queue-full test or in the gap counter change these totals. Byte reads with each enable pattern expose a wrong priority, or a bus that is not zeroed when idle.

// File: rtl/angle_out_pkg.sv
package angle_out_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BUSY = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_HIGH = 2'd1,
        RD_LOW  = 2'd2,
        RD_WIDE = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/step_queue.sv
module step_queue #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic push_up_i,
    input  logic pop_i,
    output logic empty_o,
    output logic head_up_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] dir;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } q_state_t;

    q_state_t s_d, s_q;
    logic     do_pop, do_push;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_pop  = pop_i && (s_q.cnt != '0);
        do_push = push_i && ((s_q.cnt != CNT_W'(DEPTH)) || do_pop);
        if (do_push) begin
            s_d.dir[s_q.wr] = push_up_i;
            s_d.wr          = ptr_next(s_q.wr);
        end
        if (do_pop) begin
            s_d.rd = ptr_next(s_q.rd);
        end
        if (do_push && !do_pop) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign empty_o   = (s_q.cnt == '0);
    assign head_up_o = s_q.dir[s_q.rd];

    // R5: the number of waiting steps never exceeds the queue depth
    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    // R5: a full queue with no departure drops the incoming request
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_W'(DEPTH) && push_i && !pop_i) |=> (s_q.cnt == CNT_W'(DEPTH)));

endmodule

// File: rtl/pulse_sequencer.sv
module pulse_sequencer
    import angle_out_pkg::*;
#(
    parameter int ANG_W     = 16,
    parameter int BUSY_CYC  = 4,
    parameter int GAP_W     = 4,
    parameter int COARSE_SH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             have_step_i,
    input  logic             head_up_i,
    input  logic             res_hi_i,
    input  logic [GAP_W-1:0] gap_cfg_i,
    output logic             pop_o,
    output logic [ANG_W-1:0] angle_o,
    output logic             busy_o,
    output logic             busy_end_o
);
    localparam int BC_W  = $clog2(BUSY_CYC + 1);
    localparam int CNT_W = (GAP_W > BC_W) ? GAP_W : BC_W;
    localparam int HI_W  = ANG_W - COARSE_SH;
    localparam int BL_W  = $clog2(BUSY_CYC + 2);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [ANG_W-1:0] ang;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [ANG_W-1:0] next_angle(
        input logic [ANG_W-1:0] a,
        input logic             up,
        input logic             fine
    );
        logic [HI_W-1:0] hi;
        if (fine) begin
            return up ? a + ANG_W'(1) : a - ANG_W'(1);
        end
        hi = a[ANG_W-1:COARSE_SH];
        hi = up ? hi + HI_W'(1) : hi - HI_W'(1);
        return {hi, {COARSE_SH{1'b0}}};
    endfunction

    always_comb begin
        s_d   = s_q;
        pop_o = 1'b0;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (have_step_i) begin
                    pop_o    = 1'b1;
                    s_d.ang  = next_angle(s_q.ang, head_up_i, res_hi_i);
                    s_d.st   = SEQ_BUSY;
                    s_d.cnt  = CNT_W'(BUSY_CYC - 1);
                end
            end
            SEQ_BUSY: begin
                if (s_q.cnt == '0) begin
                    if (gap_cfg_i == '0) begin
                        s_d.st = SEQ_IDLE;
                    end else begin
                        s_d.st  = SEQ_GAP;
                        s_d.cnt = CNT_W'(gap_cfg_i) - 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SEQ_GAP: begin
                if (s_q.cnt == '0) begin
                    s_d.st = SEQ_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, cnt: '0, ang: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign angle_o    = s_q.ang;
    assign busy_o     = (s_q.st == SEQ_BUSY);
    assign busy_end_o = busy_o && (s_q.cnt == '0);

    // checker state: pulse length, low time and gap captured at pulse end
    logic [BL_W-1:0]  chk_blen_q;
    logic [GAP_W:0]   chk_low_q;
    logic [GAP_W-1:0] chk_gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_blen_q <= '0;
            chk_low_q  <= '1;
            chk_gap_q  <= '0;
        end else begin
            chk_blen_q <= busy_o ? chk_blen_q + 1'b1 : '0;
            if (busy_o) begin
                chk_low_q <= '0;
            end else if (chk_low_q != '1) begin
                chk_low_q <= chk_low_q + 1'b1;
            end
            if (busy_end_o) begin
                chk_gap_q <= gap_cfg_i;
            end
        end
    end

    // R1: the count moves only on the edge that starts a pulse
    p_angle_with_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ang != $past(s_q.ang)) |-> (busy_o && !$past(busy_o)));

    // R2: a coarse step leaves the low bits clear
    p_coarse_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$past(busy_o) && !$past(res_hi_i)) |-> (s_q.ang[COARSE_SH-1:0] == '0));

    // R3: each pulse lasts exactly BUSY_CYC cycles
    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (chk_blen_q == BL_W'(BUSY_CYC)));

    // R4: the low time before a pulse respects the gap captured at the previous end
    p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (chk_low_q > {1'b0, chk_gap_q}));

endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
    parameter int ANG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inh_n_i,
    input  logic [ANG_W-1:0] angle_i,
    input  logic             busy_i,
    input  logic             busy_end_i,
    output logic [ANG_W-1:0] held_o
);
    typedef struct packed {
        logic [ANG_W-1:0] hold;
        logic             frozen;
    } hl_t;

    hl_t  s_d, s_q;
    logic settled, upd;

    always_comb begin
        s_d        = s_q;
        settled    = !busy_i || busy_end_i;
        upd        = (inh_n_i || !s_q.frozen) && settled;
        if (upd) begin
            s_d.hold = angle_i;
        end
        s_d.frozen = !inh_n_i && (s_q.frozen || settled);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign held_o = s_q.hold;

    // R6: no update while a pulse is still running
    p_no_mid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !busy_end_i) |=> $stable(s_q.hold));

    // R7: a freeze that persists keeps the held word constant
    p_frozen_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.frozen) && s_q.frozen) |-> $stable(s_q.hold));

    // R8: a freeze only begins outside a pulse or at its final edge
    p_freeze_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.frozen) |-> (!$past(busy_i) || $past(busy_end_i)));

    // R9: a released, settled edge loads the current count
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_n_i && !busy_i) |=> (s_q.hold == $past(angle_i)));

endmodule

// File: rtl/byte_readout.sv
module byte_readout
    import angle_out_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [2*BYTE_W-1:0] held_i,
    input  logic                en_msb_n_i,
    input  logic                en_lsb_n_i,
    output logic [BYTE_W-1:0]   bus_data_o,
    output logic                bus_drive_o,
    output logic [2*BYTE_W-1:0] wide_data_o,
    output logic                wide_drive_o
);
    localparam int WORD_W = 2 * BYTE_W;

    rd_sel_e sel;

    always_comb begin
        if (!en_msb_n_i && !en_lsb_n_i) begin
            sel = RD_WIDE;
        end else if (!en_msb_n_i) begin
            sel = RD_HIGH;
        end else if (!en_lsb_n_i) begin
            sel = RD_LOW;
        end else begin
            sel = RD_NONE;
        end
    end

    always_comb begin
        bus_data_o   = '0;
        bus_drive_o  = 1'b0;
        wide_data_o  = '0;
        wide_drive_o = 1'b0;
        unique case (sel)
            RD_WIDE: begin
                bus_data_o   = held_i[WORD_W-1:BYTE_W];
                bus_drive_o  = 1'b1;
                wide_data_o  = held_i;
                wide_drive_o = 1'b1;
            end
            RD_HIGH: begin
                bus_data_o  = held_i[WORD_W-1:BYTE_W];
                bus_drive_o = 1'b1;
            end
            RD_LOW: begin
                bus_data_o  = held_i[BYTE_W-1:0];
                bus_drive_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R11: both enables high leaves every output quiet
    always_comb begin
        if (en_msb_n_i && en_lsb_n_i) begin
            p_quiet_r11: assert (!bus_drive_o && !wide_drive_o
                                 && bus_data_o == '0 && wide_data_o == '0);
        end
    end

endmodule

// File: rtl/angle_out_latch.sv
module angle_out_latch #(
    parameter int BYTE_W    = 8,
    parameter int BUSY_CYC  = 4,
    parameter int GAP_W     = 4,
    parameter int Q_DEPTH   = 4,
    parameter int COARSE_SH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_req,
    input  logic                step_up,
    input  logic                res_hi,
    input  logic [GAP_W-1:0]    gap_cfg,
    input  logic                inh_n,
    input  logic                en_msb_n,
    input  logic                en_lsb_n,
    output logic                busy,
    output logic [BYTE_W-1:0]   bus_data,
    output logic                bus_drive,
    output logic [2*BYTE_W-1:0] wide_data,
    output logic                wide_drive
);
    localparam int ANG_W = 2 * BYTE_W;

    logic             q_empty, q_head_up, q_pop;
    logic [ANG_W-1:0] angle, held;
    logic             busy_end;

    step_queue #(.DEPTH(Q_DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (step_req),
        .push_up_i (step_up),
        .pop_i     (q_pop),
        .empty_o   (q_empty),
        .head_up_o (q_head_up)
    );

    pulse_sequencer #(
        .ANG_W     (ANG_W),
        .BUSY_CYC  (BUSY_CYC),
        .GAP_W     (GAP_W),
        .COARSE_SH (COARSE_SH)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .have_step_i (!q_empty),
        .head_up_i   (q_head_up),
        .res_hi_i    (res_hi),
        .gap_cfg_i   (gap_cfg),
        .pop_o       (q_pop),
        .angle_o     (angle),
        .busy_o      (busy),
        .busy_end_o  (busy_end)
    );

    hold_latch #(.ANG_W(ANG_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .inh_n_i    (inh_n),
        .angle_i    (angle),
        .busy_i     (busy),
        .busy_end_i (busy_end),
        .held_o     (held)
    );

    byte_readout #(.BYTE_W(BYTE_W)) u_read (
        .held_i       (held),
        .en_msb_n_i   (en_msb_n),
        .en_lsb_n_i   (en_lsb_n),
        .bus_data_o   (bus_data),
        .bus_drive_o  (bus_drive),
        .wide_data_o  (wide_data),
        .wide_drive_o (wide_drive)
    );

endmodule

// File: tb/tb_angle_out_latch.sv
module tb_angle_out_latch;
    localparam int BUSY = 4;
    localparam int QD   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_req = 1'b0, step_up = 1'b1, res_hi = 1'b1;
    logic [3:0]  gap_cfg = 4'd0;
    logic        inh_n = 1'b1, en_msb_n = 1'b1, en_lsb_n = 1'b1;
    logic        busy, bus_drive, wide_drive;
    logic [7:0]  bus_data;
    logic [15:0] wide_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    angle_out_latch dut (
        .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_up(step_up),
        .res_hi(res_hi), .gap_cfg(gap_cfg), .inh_n(inh_n),
        .en_msb_n(en_msb_n), .en_lsb_n(en_lsb_n), .busy(busy),
        .bus_data(bus_data), .bus_drive(bus_drive),
        .wide_data(wide_data), .wide_drive(wide_drive)
    );

    // reference model built from the requirements
    int          m_phase = 0, m_cnt = 0, m_qn = 0;
    logic [15:0] m_ang = '0, m_hold = '0;
    bit          m_frz = 1'b0;
    bit          m_qd [QD];

    function automatic logic [15:0] ref_step(logic [15:0] a, bit up, bit fine);
        logic [13:0] hi;
        if (fine) return up ? a + 16'd1 : a - 16'd1;
        hi = a[15:2];
        hi = up ? hi + 14'd1 : hi - 14'd1;
        return {hi, 2'b00};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        bit bend, upd, nfrz, pop, dir;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_qn = 0;
            m_ang = '0; m_hold = '0; m_frz = 1'b0;
        end else begin
            bend = (m_phase == 1 && m_cnt == 0);
            upd  = (inh_n || !m_frz) && (m_phase != 1 || bend);
            nfrz = !inh_n && (m_frz || m_phase != 1 || bend);
            if (upd) m_hold = m_ang;
            m_frz = nfrz;
            pop = (m_phase == 0 && m_qn > 0);
            if (pop) begin
                dir = m_qd[0];
                for (int i = 0; i < QD - 1; i++) m_qd[i] = m_qd[i+1];
                m_qn--;
                m_ang   = ref_step(m_ang, dir, res_hi);
                m_phase = 1;
                m_cnt   = BUSY - 1;
            end else if (m_phase == 1) begin
                if (m_cnt == 0) begin
                    m_phase = (gap_cfg == 0) ? 0 : 2;
                    m_cnt   = int'(gap_cfg) - 1;
                end else m_cnt--;
            end else if (m_phase == 2) begin
                if (m_cnt == 0) m_phase = 0;
                else m_cnt--;
            end
            if (step_req && m_qn < QD) begin
                m_qd[m_qn] = step_up;
                m_qn++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        logic [7:0]  eb;
        logic [15:0] ew;
        #3;
        if (rst_n && !done) begin
            eb = !en_msb_n ? m_hold[15:8] : (!en_lsb_n ? m_hold[7:0] : 8'h00);
            ew = (!en_msb_n && !en_lsb_n) ? m_hold : 16'h0000;
            chk("R3 busy", {31'd0, busy}, {31'd0, m_phase == 1});
            chk("R10 bus_data", {24'd0, bus_data}, {24'd0, eb});
            chk("R11 bus_drive", {31'd0, bus_drive}, {31'd0, !en_msb_n || !en_lsb_n});
            chk("R12 wide_data", {16'd0, wide_data}, {16'd0, ew});
            chk("R12 wide_drive", {31'd0, wide_drive}, {31'd0, !en_msb_n && !en_lsb_n});
        end
    end

    task automatic do_step(input bit up, input bit fine);
        @(negedge clk);
        step_req = 1'b1; step_up = up; res_hi = fine;
        @(negedge clk);
        step_req = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic read_wide(output logic [15:0] v);
        @(negedge clk);
        en_msb_n = 1'b0; en_lsb_n = 1'b0;
        #3 v = wide_data;
        @(negedge clk);
        en_msb_n = 1'b1; en_lsb_n = 1'b1;
    endtask

    task automatic wait_busy();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #3;
            if (busy) break;
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #3;
            if (!busy) break;
        end
        n = 1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #3;
            if (busy) break;
            n++;
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            vectors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v0;
        int n;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        #3 chk("R13 busy after reset", {31'd0, busy}, 32'd0);
        read_wide(v);
        chk("R13 held after reset", {16'd0, v}, 32'h0000);

        // R1 wrap in both directions
        do_step(1'b0, 1'b1); settle(); read_wide(v);
        chk("R1 down wrap", {16'd0, v}, 32'hFFFF);
        do_step(1'b1, 1'b1); settle(); read_wide(v);
        chk("R1 up wrap", {16'd0, v}, 32'h0000);

        // R2 coarse stepping from unaligned count
        for (int i = 0; i < 5; i++) do_step(1'b1, 1'b1);
        settle();
        do_step(1'b1, 1'b0); settle(); read_wide(v);
        chk("R2 coarse up", {16'd0, v}, 32'h0008);
        do_step(1'b0, 1'b0); settle(); read_wide(v);
        chk("R2 coarse down", {16'd0, v}, 32'h0004);
        res_hi = 1'b1;

        // R10 / R11 byte reads
        @(negedge clk); en_msb_n = 1'b0; #3
        chk("R10 msb byte", {24'd0, bus_data}, 32'h00);
        @(negedge clk); en_msb_n = 1'b1; en_lsb_n = 1'b0; #3
        chk("R10 lsb byte", {24'd0, bus_data}, 32'h04);
        chk("R12 single enable no wide", {31'd0, wide_drive}, 32'd0);
        @(negedge clk); en_lsb_n = 1'b1; #3
        chk("R11 idle bus", {31'd0, bus_drive}, 32'd0);

        // R3 pulse width
        do_step(1'b1, 1'b1);
        wait_busy();
        n = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #3;
            if (!busy) break;
            n++;
        end
        chk("R3 busy width", n, BUSY);
        settle();

        // R4 gap timing with backlog
        gap_cfg = 4'd3;
        @(negedge clk); step_req = 1'b1; step_up = 1'b1;
        @(negedge clk); @(negedge clk); step_req = 1'b0;
        wait_busy(); count_low(n);
        chk("R4 gap 3", n, 4);
        settle();
        gap_cfg = 4'd0;
        @(negedge clk); step_req = 1'b1;
        @(negedge clk); @(negedge clk); step_req = 1'b0;
        wait_busy(); count_low(n);
        chk("R4 gap 0", n, 1);
        settle();

        // R5 burst into a full queue
        gap_cfg = 4'd5;
        read_wide(v0);
        @(negedge clk); step_req = 1'b1; step_up = 1'b1;
        repeat (6) @(negedge clk);
        step_req = 1'b0;
        repeat (120) @(negedge clk);
        read_wide(v);
        chk("R5 burst of six keeps five", {16'd0, v}, {16'd0, v0 + 16'd5});
        gap_cfg = 4'd0;

        // R6 / R8 / R7 / R9 inhibit around a pulse
        read_wide(v0);
        do_step(1'b1, 1'b1);
        wait_busy();
        read_wide(v);
        chk("R6 mid pulse shows old", {16'd0, v}, {16'd0, v0});
        @(negedge clk); inh_n = 1'b0;
        settle(); read_wide(v);
        chk("R8 deferred freeze captures new", {16'd0, v}, {16'd0, v0 + 16'd1});
        do_step(1'b1, 1'b1); settle(); read_wide(v);
        chk("R7 frozen while count moves", {16'd0, v}, {16'd0, v0 + 16'd1});
        @(negedge clk); inh_n = 1'b1;
        read_wide(v);
        chk("R9 release shows new count", {16'd0, v}, {16'd0, v0 + 16'd2});

        // R7 freeze applied while idle
        @(negedge clk); inh_n = 1'b0;
        do_step(1'b0, 1'b1); settle(); read_wide(v);
        chk("R7 idle freeze", {16'd0, v}, {16'd0, v0 + 16'd2});
        @(negedge clk); inh_n = 1'b1;
        read_wide(v);
        chk("R9 release after idle freeze", {16'd0, v}, {16'd0, v0 + 16'd1});

        // random phase checked by the model comparison
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            step_req = (($urandom % 10) < 3);
            step_up  = $urandom % 2;
            if (($urandom % 16) == 0) res_hi = ~res_hi;
            if (($urandom % 8) == 0) inh_n = ~inh_n;
            en_msb_n = $urandom % 2;
            en_lsb_n = $urandom % 2;
            if (($urandom % 200) == 0) gap_cfg = 4'($urandom % 7);
        end
        @(negedge clk);
        step_req = 1'b0; inh_n = 1'b1; en_msb_n = 1'b1; en_lsb_n = 1'b1;
        repeat (80) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule